// File: doc/BRIEF.md
# Timeslot Bit Extractor for an HDLC Receive Path

This block takes a framed T1 or E1 receive bit stream, one bit per clock, and marks the bits that belong to an HDLC receiver. For each marked bit it raises a one-cycle strobe, with the bit itself alongside. An upstream framer supplies a frame-start pulse on the first bit of every frame and a frame-parity flag. Software picks the bits through a small write-only register port. It can select any set of channels, adjacent or scattered, and drop chosen bit positions inside those channels. It can also switch to a link mode that takes either the T1 data-link framing bits or a chosen set of the E1 spare bits in timeslot 0.

Register writes go to a shadow copy. The shadow copy moves to the working copy on the next frame-start pulse, so a frame is always decoded with one consistent mapping. Frame alignment, flag hunting and CRC checks are done elsewhere.

Top module: `ts_bit_extract`

## Requirements
- R1: After reset every channel-select bit is 0, the skip mask is 0 and the mode is T1 channel mode, so no strobe is raised until a mapping is written.
- R2: Register address k (0..3), bit n selects channel 8k+n+1. In T1 mode channels 1..24 follow the framing bit at frame positions 1..192. In E1 mode channels 1..32 fill frame positions 0..255.
- R3: Any combination of selected channels is extracted, adjacent or not, and each taken bit appears on hd_data as it was received.
- R4: Address 4 is the skip mask: bit i set excludes arrival position i+1 (1 = first bit of the channel) in every selected channel.
- R5: In T1 channel mode the framing bit (frame position 0) is never extracted.
- R6: Address 5 holds the mode: bit 0 = link mode, bit 1 = E1 (0 = T1). In T1 link mode only the framing bit is taken, and only in frames whose parity flag is 0.
- R7: In E1 link mode, arrival positions 4..8 of timeslot 0 are taken only in frames whose parity flag is 1, and only where address 6 bit j (position 4+j) is set.
- R8: hd_valid is high for exactly one cycle per extracted bit, one cycle after that bit is presented. It is low for every other bit, and hd_data is 0 whenever hd_valid is low.
- R9: A write takes effect at the first frame-start pulse after the write cycle. A write in the same cycle as a frame-start pulse waits for the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial data bit |
| frm_start | input | 1 | High on the first bit of each frame |
| frm_par | input | 1 | Frame parity within the multiframe, sampled with frm_start |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| hd_valid | output | 1 | Strobe for an extracted bit |
| hd_data | output | 1 | Extracted bit |

## Verification
The risky overlap is a register write landing on the same bit as a frame-start pulse, where the mapping swap and the write could race. The bench writes the select register at address 0 exactly on the frame-start bit. It then expects the old mapping for the whole of the new frame and the new one only from the frame after. This is judged bit by bit against a bench model that applies its pending copy before it accepts that cycle's write. A second overlap is a change of T1/E1 mode written while frames of the other length are still arriving. This is checked across the frame where the decoding flips.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  localparam int NUM_SEL_REGS = 4;
  localparam int SEL_W        = 8;
  localparam int NUM_CH       = NUM_SEL_REGS * SEL_W;
  localparam int SA_BITS      = 5;

  typedef struct packed {
    logic [NUM_CH-1:0]  ch_sel;
    logic [SEL_W-1:0]   skip;
    logic               e1_mode;
    logic               link_mode;
    logic [SA_BITS-1:0] sa_en;
  } map_cfg_t;
endpackage

// File: rtl/tsx_cfg_regs.sv
module tsx_cfg_regs
  import tsx_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SEL_W-1:0]  wr_data,
  input  logic              frm_start,
  output map_cfg_t          cfg_now
);
  localparam int ADR_SKIP = NUM_SEL_REGS;
  localparam int ADR_MODE = NUM_SEL_REGS + 1;
  localparam int ADR_SA   = NUM_SEL_REGS + 2;

  map_cfg_t shadow_q, shadow_d, act_q;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) begin
      for (int k = 0; k < NUM_SEL_REGS; k++) begin
        if (wr_addr == ADDR_W'(k)) shadow_d.ch_sel[k*SEL_W +: SEL_W] = wr_data;
      end
      if (wr_addr == ADDR_W'(ADR_SKIP)) shadow_d.skip = wr_data;
      if (wr_addr == ADDR_W'(ADR_MODE)) begin
        shadow_d.link_mode = wr_data[0];
        shadow_d.e1_mode   = wr_data[1];
      end
      if (wr_addr == ADDR_W'(ADR_SA)) shadow_d.sa_en = wr_data[SA_BITS-1:0];
    end
  end

  assign cfg_now = frm_start ? shadow_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= cfg_now;
    end
  end

  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> $stable(act_q));
endmodule

// File: rtl/tsx_pos_cnt.sv
module tsx_pos_cnt #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             frm_par,
  output logic [POS_W-1:0] pos,
  output logic             par
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, pos_d;
  logic             par_q;

  assign pos = frm_start ? '0 : pos_q;
  assign par = frm_start ? frm_par : par_q;

  always_comb begin
    if (pos == POS_MAX) pos_d = POS_MAX;
    else                pos_d = pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= POS_MAX;
      par_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      par_q <= par;
    end
  end

  // R2
  pos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (pos_q == POS_W'(1)));
endmodule

// File: rtl/tsx_pick.sv
module tsx_pick
  import tsx_pkg::*;
#(
  parameter int POS_W  = 9,
  parameter int T1_LEN = 193,
  parameter int E1_LEN = 256
) (
  input  map_cfg_t         cfg,
  input  logic [POS_W-1:0] pos,
  input  logic             par,
  output logic             take
);
  logic [7:0] off;
  logic [4:0] ch;
  logic [2:0] bp;
  logic       in_payload, chan_take, fdl_take, sa_take;
  logic [SEL_W-1:0] sa_vec;

  always_comb begin
    off        = cfg.e1_mode ? pos[7:0] : (pos[7:0] - 8'd1);
    ch         = off[7:3];
    bp         = off[2:0];
    in_payload = cfg.e1_mode ? (pos < POS_W'(E1_LEN))
                             : ((pos != '0) && (pos < POS_W'(T1_LEN)));
    chan_take  = in_payload && cfg.ch_sel[ch] && !cfg.skip[bp];
    fdl_take   = !cfg.e1_mode && (pos == '0) && !par;
    sa_vec     = {cfg.sa_en, 3'b000};
    sa_take    = cfg.e1_mode && (pos < POS_W'(SEL_W)) && par && sa_vec[bp];
    take       = cfg.link_mode ? (fdl_take || sa_take) : chan_take;
  end
endmodule

// File: rtl/ts_bit_extract.sv
module ts_bit_extract
  import tsx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int POS_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              frm_start,
  input  logic              frm_par,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hd_valid,
  output logic              hd_data
);
  logic             rst_meta, rst_n_s;
  map_cfg_t         cfg_now;
  logic [POS_W-1:0] pos;
  logic             par, take;
  logic             valid_d, data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  tsx_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frm_start(frm_start), .cfg_now(cfg_now)
  );

  tsx_pos_cnt #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n_s), .frm_start(frm_start), .frm_par(frm_par),
    .pos(pos), .par(par)
  );

  tsx_pick #(.POS_W(POS_W)) u_pick (
    .cfg(cfg_now), .pos(pos), .par(par), .take(take)
  );

  always_comb begin
    valid_d = take;
    data_d  = take && rx_bit;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hd_valid <= 1'b0;
      hd_data  <= 1'b0;
    end else begin
      hd_valid <= valid_d;
      hd_data  <= data_d;
    end
  end

  // R1
  no_map_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_now.ch_sel == '0 && !cfg_now.link_mode) |=> !hd_valid);
  // R5
  t1_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frm_start && !cfg_now.e1_mode && !cfg_now.link_mode) |=> !hd_valid);
  // R7
  sa_window_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_now.link_mode && cfg_now.e1_mode && pos >= POS_W'(8)) |=> !hd_valid);
  // R8
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !hd_valid |-> !hd_data);
endmodule

// File: tb/ts_bit_extract_bench.sv
module ts_bit_extract_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_bit, frm_start, frm_par, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       hd_valid, hd_data;

  int total = 0;
  int bad   = 0;

  ts_bit_extract u_ts_bit_extract (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .frm_start(frm_start),
    .frm_par(frm_par), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hd_valid(hd_valid), .hd_data(hd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model: pending (written) and applied (in force) mapping
  logic [31:0] p_sel, a_sel, nx_sel;
  logic [7:0]  p_skip, a_skip, nx_skip;
  logic        p_link, a_link, nx_link, p_e1, a_e1, nx_e1;
  logic [4:0]  p_sa, a_sa, nx_sa;
  logic        exp_v, exp_d, have_exp;
  string       tag;

  function automatic logic model_take(int p, logic fpar);
    int ch, b;
    if (a_link) begin
      if (!a_e1) return (p == 0) && !fpar;
      if (p >= 8 || !fpar) return 1'b0;
      b = p + 1;
      return (b >= 4) && a_sa[b-4];
    end
    if (a_e1) begin
      if (p > 255) return 1'b0;
      ch = p / 8 + 1; b = p % 8 + 1;
    end else begin
      if (p < 1 || p > 192) return 1'b0;
      ch = (p - 1) / 8 + 1; b = (p - 1) % 8 + 1;
    end
    return a_sel[ch-1] && !a_skip[b-1];
  endfunction

  task automatic check_out();
    if (have_exp) begin
      total++;
      if (hd_valid !== exp_v || hd_data !== exp_d) begin
        bad++;
        $display("FAIL %s: valid/data=%b%b expected %b%b", tag, hd_valid, hd_data, exp_v, exp_d);
      end
    end
  endtask

  task automatic run_frame(input int len, input logic fpar, input logic wr);
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      check_out();
      rx_bit    = 1'($urandom);
      frm_start = (p == 0);
      frm_par   = fpar;
      wr_en     = 1'b0;
      if (p == 0) begin
        a_sel = p_sel; a_skip = p_skip; a_link = p_link; a_e1 = p_e1; a_sa = p_sa;
      end
      exp_v    = model_take(p, fpar);
      exp_d    = exp_v & rx_bit;
      have_exp = 1'b1;
      if (wr && p < 7) begin
        wr_en   = 1'b1;
        wr_addr = 3'(p);
        case (p)
          0, 1, 2, 3: begin wr_data = nx_sel[p*8 +: 8]; p_sel[p*8 +: 8] = nx_sel[p*8 +: 8]; end
          4: begin wr_data = nx_skip; p_skip = nx_skip; end
          5: begin wr_data = {6'd0, nx_e1, nx_link}; p_e1 = nx_e1; p_link = nx_link; end
          default: begin wr_data = {3'd0, nx_sa}; p_sa = nx_sa; end
        endcase
      end
    end
  endtask

  task automatic set_next(input logic [31:0] s, input logic [7:0] k, input logic e1,
                          input logic lk, input logic [4:0] sa);
    nx_sel = s; nx_skip = k; nx_e1 = e1; nx_link = lk; nx_sa = sa;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_bit = 1'b0; frm_start = 1'b0; frm_par = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; have_exp = 1'b0;
    p_sel = '0; p_skip = '0; p_link = 1'b0; p_e1 = 1'b0; p_sa = '0;
    a_sel = '0; a_skip = '0; a_link = 1'b0; a_e1 = 1'b0; a_sa = '0;
    tag = "R1";
    repeat (4) begin
      @(negedge clk);
      total++;
      if (hd_valid !== 1'b0) begin
        bad++;
        $display("FAIL R1: valid in reset=%b expected 0", hd_valid);
      end
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: default mapping takes nothing
    run_frame(193, 1'b0, 1'b0);
    run_frame(193, 1'b1, 1'b0);
    // R9: writes during this frame, including one on the frame-start bit
    tag = "R9";
    set_next(32'h8024_0081, 8'h00, 1'b0, 1'b0, 5'd0);
    run_frame(193, 1'b0, 1'b1);
    tag = "R2";
    run_frame(193, 1'b1, 1'b0);
    // R4: skip mask
    tag = "R4";
    set_next(32'h8024_0081, 8'h5A, 1'b0, 1'b0, 5'd0);
    run_frame(193, 1'b0, 1'b1);
    run_frame(193, 1'b1, 1'b0);
    // R3: scattered channel sets
    tag = "R3";
    set_next(32'h00AA_00FF, 8'h00, 1'b0, 1'b0, 5'd0);
    run_frame(193, 1'b0, 1'b1);
    run_frame(193, 1'b1, 1'b0);
    // R5: every T1 channel selected, framing bit must stay out
    tag = "R5";
    set_next(32'hFFFF_FFFF, 8'h00, 1'b0, 1'b0, 5'd0);
    run_frame(193, 1'b0, 1'b1);
    run_frame(193, 1'b0, 1'b0);
    // R6: T1 data-link bits
    tag = "R6";
    set_next(32'hFFFF_FFFF, 8'h00, 1'b0, 1'b1, 5'd0);
    run_frame(193, 1'b1, 1'b1);
    for (int f = 0; f < 6; f++) run_frame(193, 1'(f), 1'b0);
    // R2: E1 channel mapping, mode change written during a T1 frame
    tag = "R2";
    set_next(32'hC310_8001, 8'h81, 1'b1, 1'b0, 5'd0);
    run_frame(193, 1'b0, 1'b1);
    run_frame(256, 1'b1, 1'b0);
    run_frame(256, 1'b0, 1'b0);
    // R7: E1 spare bits
    tag = "R7";
    set_next(32'h0, 8'h00, 1'b1, 1'b1, 5'h15);
    run_frame(256, 1'b0, 1'b1);
    for (int f = 0; f < 4; f++) run_frame(256, 1'(f), 1'b0);
    set_next(32'h0, 8'h00, 1'b1, 1'b1, 5'h0A);
    run_frame(256, 1'b0, 1'b1);
    for (int f = 0; f < 2; f++) run_frame(256, 1'(f), 1'b0);
    // R8: sweep of random mappings in both line modes
    tag = "R8";
    for (int s = 0; s < 8; s++) begin
      set_next($urandom, 8'($urandom), 1'(s[0]), 1'b0, 5'd0);
      run_frame(p_e1 ? 256 : 193, 1'(s), 1'b1);
      run_frame(nx_e1 ? 256 : 193, 1'(s + 1), 1'b0);
    end
    @(negedge clk);
    check_out();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule